// File: doc/BRIEF.md
# Cascadable Segment Column Driver Core

This block is the digital core of a dot-matrix column driver with 80 segment outputs. Display data arrives as 4-bit nibbles on a bus that several drivers share. A nibble is taken on each falling edge of a shift-clock input, but only while the device holds the chain enable. Nibbles fill a line register in one of two directions. When a device has taken its twentieth nibble, it drives its chain output low so that the next device in the chain starts to capture. After that it ignores the bus.

A falling edge on the load input copies the line into a hold register and re-arms capture for the next line. Every output is a 2-bit drive-level code. The code is computed from the held bit, the frame-alternation phase and an active-low display-off input. The shift-clock and load inputs are sampled on a single system clock, and their falling edges are detected inside the block.

Top module: `seg_column_driver`

## Requirements
- R1: One nibble is captured per falling edge of `shift_clk`, on the first rising `clk` edge that sees the input low after it was high. Twenty captures fill the 80-bit line.
- R2: With `dir_rev` low, nibble k (counting from 0) goes to outputs 4k+1..4k+4, with `nib[0]` on the lowest number. Output n drives `lvl[2n-1:2n-2]`.
- R3: With `dir_rev` high, nibble k goes to outputs 80-4k down to 77-4k, with `nib[0]` on the highest number of the four.
- R4: On the clock edge that captures the twentieth nibble, `chain_out_n` goes low. Further shift strobes are ignored until a load.
- R5: Capture is enabled only while `chain_in_n` is low. Strobes seen while it is high leave the line unchanged.
- R6: A falling edge of `load_in` copies the line into the hold register. At no other time does the hold register change.
- R7: A load strobe drives `chain_out_n` high and restarts the nibble count, so the next line fills from nibble 0.
- R8: With `disp_off_n` high, each output code is 00 for alternation 0 and data 1, 01 for alternation 0 and data 0, 10 for alternation 1 and data 0, and 11 for alternation 1 and data 1.
- R9: With `disp_off_n` low, every output code is 00.
- R10: Reset clears the line and hold registers and the enable, and drives `chain_out_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_clk | input | 1 | Data shift clock; its falling edge takes a nibble |
| load_in | input | 1 | Line load; its falling edge copies the line to the hold register |
| chain_in_n | input | 1 | Active-low enable from the previous device, or tied low |
| dir_rev | input | 1 | Loading direction: 0 starts at output 1, 1 starts at output 80 |
| nib | input | 4 | Display data nibble |
| alt_phase | input | 1 | Frame alternation phase |
| disp_off_n | input | 1 | Active-low display off |
| chain_out_n | output | 1 | Active-low enable to the next device |
| lvl | output | 160 | Two-bit drive-level code for each of the 80 outputs |

## Verification
A falling edge on `shift_clk` or `load_in` takes effect at the first rising clock edge after it. The line, the count and `chain_out_n` are updated at that edge. `lvl` follows the hold register, `alt_phase` and `disp_off_n` combinationally, within the same cycle. The bench holds every level of the shift and load inputs for at least two clocks and samples at falling clock edges afterwards, so each result is already settled when it is read.

// File: rtl/seg_column_driver.sv
module seg_column_driver #(
  parameter int N_OUT = 80,
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_clk,
  input  logic                 load_in,
  input  logic                 chain_in_n,
  input  logic                 dir_rev,
  input  logic [NIB_W-1:0]     nib,
  input  logic                 alt_phase,
  input  logic                 disp_off_n,
  output logic                 chain_out_n,
  output logic [2*N_OUT-1:0]   lvl
);
  localparam int N_STB = N_OUT / NIB_W;
  localparam int CW    = $clog2(N_STB + 1);

  logic             shift_q, load_q, en, done;
  logic [CW-1:0]    cnt;
  logic [N_OUT-1:0] line_r, line_nx, hold_r;

  wire shift_stb = shift_q & ~shift_clk;
  wire load_stb  = load_q & ~load_in;
  wire take      = shift_stb & en & ~load_stb;
  wire last      = (cnt == CW'(N_STB - 1));

  for (genvar j = 0; j < N_OUT; j++) begin : g_slot
    localparam int PF = j / NIB_W;
    localparam int BF = j % NIB_W;
    localparam int PR = (N_OUT - 1 - j) / NIB_W;
    localparam int BR = (N_OUT - 1 - j) % NIB_W;
    wire       hit = (cnt == (dir_rev ? CW'(PR) : CW'(PF)));
    wire       bit_in = dir_rev ? nib[BR] : nib[BF];
    assign line_nx[j] = hit ? bit_in : line_r[j];
    assign lvl[2*j +: 2] = disp_off_n ? {alt_phase, ~(alt_phase ^ hold_r[j])} : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= 1'b0;
      load_q  <= 1'b0;
      en      <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      line_r  <= '0;
      hold_r  <= '0;
    end else begin
      shift_q <= shift_clk;
      load_q  <= load_in;
      if (load_stb) begin
        hold_r <= line_r;
        cnt    <= '0;
        done   <= 1'b0;
      end else if (take) begin
        line_r <= line_nx;
        cnt    <= cnt + 1'b1;
        if (last) done <= 1'b1;
      end
      en <= ~chain_in_n & (load_stb | ~(done | (take & last)));
    end
  end

  assign chain_out_n = ~done;

endmodule

// File: rtl/seg_column_driver_chk.sv
module seg_column_driver_chk #(
  parameter int N_OUT = 80,
  parameter int N_STB = 20,
  parameter int CW    = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load_stb,
  input logic               en,
  input logic               chain_out_n,
  input logic [CW-1:0]      cnt,
  input logic [N_OUT-1:0]   line_r,
  input logic [N_OUT-1:0]   hold_r,
  input logic               disp_off_n,
  input logic [2*N_OUT-1:0] lvl
);
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(N_STB));

  assert_full_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_out_n && !load_stb |=> !chain_out_n);

  assert_idle_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(line_r));

  assert_hold_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb |=> $stable(hold_r));

  assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> chain_out_n);

  assert_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_off_n |-> (lvl == '0));
endmodule

bind seg_column_driver seg_column_driver_chk #(
  .N_OUT(N_OUT), .N_STB(N_STB), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .en(en),
  .chain_out_n(chain_out_n), .cnt(cnt), .line_r(line_r), .hold_r(hold_r),
  .disp_off_n(disp_off_n), .lvl(lvl)
);

// File: tb/seg_column_driver_tb_top.sv
module seg_column_driver_tb_top;
  localparam int CLK_P = 10;
  localparam int N  = 80;
  localparam int NS = 20;

  logic clk = 1'b0, rst_n = 1'b0, shc = 1'b0, ld = 1'b0, dir = 1'b0;
  logic alt = 1'b0, doff_n = 1'b1;
  logic [3:0] nib = 4'h0;
  logic c01, c12;
  logic [2*N-1:0] lv0, lv1;
  int errs = 0, checks = 0;
  bit ended = 0;

  always #(CLK_P/2) clk = ~clk;

  seg_column_driver dut_i (
    .clk(clk), .rst_n(rst_n), .shift_clk(shc), .load_in(ld), .chain_in_n(1'b0),
    .dir_rev(dir), .nib(nib), .alt_phase(alt), .disp_off_n(doff_n),
    .chain_out_n(c01), .lvl(lv0));

  seg_column_driver dut_nx_i (
    .clk(clk), .rst_n(rst_n), .shift_clk(shc), .load_in(ld), .chain_in_n(c01),
    .dir_rev(dir), .nib(nib), .alt_phase(alt), .disp_off_n(doff_n),
    .chain_out_n(c12), .lvl(lv1));

  function automatic logic [3:0] nv(int seed, int g);
    return 4'((g * seed + g / 3 + seed) & 15);
  endfunction

  function automatic logic [2*N-1:0] exp_lv(int dev, int seed, logic d, logic a, logic on);
    logic [2*N-1:0] v;
    for (int j = 0; j < N; j++) begin
      int o = d ? N - 1 - j : j;
      logic [3:0] x = nv(seed, dev * NS + o / 4);
      logic b = x[o % 4];
      v[2*j +: 2] = on ? {a, ~(a ^ b)} : 2'b00;
    end
    return v;
  endfunction

  task automatic chk_vec(string tag, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic [3:0] v);
    nib = v; shc = 1'b1; tick(2);
    shc = 1'b0; tick(2);
  endtask

  task automatic pulse_load();
    ld = 1'b1; tick(2);
    ld = 1'b0; tick(3);
  endtask

  task automatic fill(int seed);
    for (int g = 0; g < 2 * NS; g++) begin
      push(nv(seed, g));
      if (g == NS - 1) begin
        chk_bit("R4 first device chain low after 20 nibbles", c01, 1'b0);
        chk_bit("R4 second device chain still high", c12, 1'b1);
      end
    end
    chk_bit("R4 second device chain low after 40 nibbles", c12, 1'b0);
    push(4'hF);
  endtask

  task automatic sweep(string tag, int seed, logic d);
    for (int m = 0; m < 4; m++) begin
      alt = m[0]; doff_n = ~m[1]; tick(1);
      chk_vec({tag, " R8 R9 dev0"}, lv0, exp_lv(0, seed, d, alt, doff_n));
      chk_vec({tag, " R5 R8 dev1"}, lv1, exp_lv(1, seed, d, alt, doff_n));
    end
    alt = 1'b0; doff_n = 1'b1; tick(1);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk_bit("R10 chain out high dev0", c01, 1'b1);
    chk_bit("R10 chain out high dev1", c12, 1'b1);
    chk_vec("R10 cleared hold dev0", lv0, {N{2'b01}});
    chk_vec("R10 cleared hold dev1", lv1, {N{2'b01}});

    dir = 1'b0;
    fill(5);
    pulse_load();
    chk_bit("R7 chain re-armed dev0", c01, 1'b1);
    chk_bit("R7 chain re-armed dev1", c12, 1'b1);
    sweep("R2 forward", 5, 1'b0);

    dir = 1'b1;
    fill(11);
    chk_vec("R6 hold unchanged before load dev0", lv0, exp_lv(0, 5, 1'b0, 1'b0, 1'b1));
    chk_vec("R6 hold unchanged before load dev1", lv1, exp_lv(1, 5, 1'b0, 1'b0, 1'b1));
    pulse_load();
    sweep("R3 reverse", 11, 1'b1);

    dir = 1'b0;
    for (int g = 0; g < 7; g++) push(nv(3, g));
    chk_bit("R7 partial line keeps chain high", c01, 1'b1);
    pulse_load();
    fill(9);
    pulse_load();
    sweep("R7 R1 restart after partial", 9, 1'b0);

    summary();
  end
endmodule